// File: doc/BRIEF.md
# Doorbell Mailbox Circular Buffer

This block carries 32-bit words between a host processor and an embedded controller. Each direction has its own circular buffer. The host works through four register addresses: its own control/status word, a push window, a read-only view of the controller's status word, and a pop window. The controller uses a plain strobe port to pop words the host has sent and to push words back. Both sides exchange doorbells: a host status write can pulse a doorbell line to the controller, and the controller can raise an interrupt-status bit towards the host.

Pointers never wrap. The free space for the host is the depth minus its write pointer. The words waiting in a buffer are its write pointer minus its read pointer. Both buffers go back to empty only through a reset handshake. A small state machine tracks the link. LK_IDLE is the state after reset, with the host not ready. LK_FLUSH runs while a reset is in progress and lasts a programmable number of cycles, during which the controller's ready indication is masked. LK_ARMED means the host has declared itself ready. The transitions are:
- any state to LK_FLUSH on a reset command;
- LK_FLUSH to LK_IDLE when its cycle count runs out;
- LK_IDLE to LK_ARMED on a ready write;
- LK_ARMED to LK_IDLE on a write with ready=0.

Top module: `dbell_mbox`

## Requirements
- R1: After reset the host status word (address 0) reads DEPTH in bits [31:24], zero pointers in [23:16] (read) and [15:8] (write), and zero in every flag bit. host_irq and ctl_doorbell are 0. The controller status word (address 2) shows ctl_ready_in in bit 4.
- R2: A host write to address 1 stores the word in the host-to-controller buffer and advances the write pointer in bits [15:8] of address 0. Controller pops (ctl_pop) return the words in the order they were written and advance bits [23:16].
- R3: A host push while the write pointer equals DEPTH is dropped and leaves the pointer unchanged. It sets the overflow flag, bit 5 of address 0, which stays set until the next reset handshake.
- R4: A controller push (ctl_push) stores a word in the controller-to-host buffer. Host reads from address 3 return those words in order. The words waiting equal bits [15:8] minus bits [23:16] of address 2.
- R5: Popping an empty buffer from either side returns zero and leaves its read pointer unchanged.
- R6: A write to address 0 with reset (bit 3) and interrupt-generate (bit 2) both set empties both buffers and clears both overflow flags. The link then stays in LK_FLUSH for RST_CYCLES cycles; during that time bit 3 of address 2 reads 1 and its ready bit 4 reads 0. A reset bit written without interrupt-generate has no effect.
- R7: A write to address 0 with ready (bit 4) set and reset clear moves the link from LK_IDLE to LK_ARMED, and bit 4 of address 0 reads 1. A write with ready clear returns it to LK_IDLE. When LK_FLUSH ends, the link is in LK_IDLE.
- R8: Every write to address 0 with interrupt-generate set makes ctl_doorbell high for exactly the next cycle.
- R9: ctl_ring sets interrupt status (bit 1 of address 0). A host write with bit 1 set clears it; a write with bit 1 clear leaves it unchanged.
- R10: Interrupt enable is bit 0 of address 0, written directly. host_irq is high exactly when both interrupt status and interrupt enable are set.
- R11: Pushes from either side during LK_FLUSH are dropped, and no overflow is flagged for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select: 0 host status, 1 push window, 2 controller status, 3 pop window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops when address is 3) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the selected address, combinational |
| host_irq | output | 1 | Interrupt to the host |
| ctl_push | input | 1 | Controller push strobe |
| ctl_wdata | input | 32 | Controller push data |
| ctl_pop | input | 1 | Controller pop strobe |
| ctl_rdata | output | 32 | Head word of host-to-controller buffer, zero if empty |
| ctl_count | output | 8 | Words waiting for the controller |
| ctl_ready_in | input | 1 | Controller ready indication |
| ctl_ring | input | 1 | Controller raises host interrupt status |
| ctl_doorbell | output | 1 | One-cycle doorbell pulse to the controller |
| ctl_flush | output | 1 | High while the reset handshake is in progress |

## Verification
The buffers are tried with short bursts, with a fill to exactly the depth followed by one more push, and with pops of an empty buffer. Together these separate ordering errors, off-by-one faults at the full boundary, and reads that wrongly move a pointer. The status word is written with several bit combinations, among them reset without interrupt-generate, ready alone, and status bits one and zero. These show whether the write-one-to-clear rule, the doorbell and the two-bit reset condition are decoded separately. The flush is timed cycle by cycle, and a push is issued inside it to show that the push is dropped.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_FLUSH = 2'd1,
        LK_ARMED = 2'd2
    } link_e;

    localparam int unsigned B_IE    = 0;
    localparam int unsigned B_IS    = 1;
    localparam int unsigned B_IG    = 2;
    localparam int unsigned B_RST   = 3;
    localparam int unsigned B_RDY   = 4;
    localparam int unsigned B_OVF   = 5;
    localparam int unsigned FIELD_W = 8;

    localparam logic [1:0] A_HCSR = 2'd0;
    localparam logic [1:0] A_PUSH = 2'd1;
    localparam logic [1:0] A_CCSR = 2'd2;
    localparam logic [1:0] A_POP  = 2'd3;
endpackage

// File: rtl/dbm_ring.sv
module dbm_ring #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PW = $clog2(DEPTH + 1),
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [PW-1:0]     wr_ptr,
    output logic [PW-1:0]     rd_ptr,
    output logic              ovf
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic full, has_data;

    assign full     = (wr_ptr == PW'(DEPTH));
    assign has_data = (rd_ptr < wr_ptr);
    assign pop_data = has_data ? mem[rd_ptr[AW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (push && !full && !clr)
            mem[wr_ptr[AW-1:0]] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf <= 1'b1;
                else      wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop && has_data)
                rd_ptr <= rd_ptr + 1'b1;
        end
    end

    p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr <= PW'(DEPTH)) && (rd_ptr <= wr_ptr));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> ($stable(wr_ptr) && ovf));
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !has_data && !push && !clr) |=> $stable(rd_ptr));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_ptr == '0 && rd_ptr == '0 && !ovf));
endmodule

// File: rtl/dbm_link.sv
module dbm_link
    import dbm_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4,
    localparam int unsigned CW = $clog2(RST_CYCLES + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  csr_wr,
    input  logic  wr_rdy,
    input  logic  wr_rst,
    input  logic  wr_ig,
    output link_e state,
    output logic  clr,
    output logic  flush,
    output logic  armed
);
    link_e   nxt;
    logic [CW-1:0] cnt;

    assign clr = csr_wr && wr_rst && wr_ig;

    always_comb begin
        nxt = state;
        unique case (state)
            LK_IDLE:  if (csr_wr && wr_rdy && !wr_rst) nxt = LK_ARMED;
            LK_ARMED: if (csr_wr && !wr_rdy)           nxt = LK_IDLE;
            LK_FLUSH: if (cnt == '0)                   nxt = LK_IDLE;
            default:                                   nxt = LK_IDLE;
        endcase
        if (clr) nxt = LK_FLUSH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (clr)                 cnt <= CW'(RST_CYCLES - 1);
            else if (cnt != '0)      cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        flush = (state == LK_FLUSH);
        armed = (state == LK_ARMED);
    end

    p_reset_enters_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> flush);
    p_flush_exits_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !clr && cnt == '0) |=> (state == LK_IDLE));
    p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_IDLE && csr_wr && wr_rdy && !wr_rst) |=> armed);
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
    import dbm_pkg::*;
#(
    parameter int unsigned DEPTH      = 32,
    parameter int unsigned RST_CYCLES = 4,
    localparam int unsigned PW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_irq,
    input  logic        ctl_push,
    input  logic [31:0] ctl_wdata,
    input  logic        ctl_pop,
    output logic [31:0] ctl_rdata,
    output logic [7:0]  ctl_count,
    input  logic        ctl_ready_in,
    input  logic        ctl_ring,
    output logic        ctl_doorbell
    ,output logic       ctl_flush
);
    link_e         state;
    logic          clr, flush, armed, csr_wr;
    logic          int_sts, int_en, bell_q;
    logic [PW-1:0] h_wp, h_rp, c_wp, c_rp;
    logic          h_ovf, c_ovf;
    logic [31:0]   h_pop_data;

    assign csr_wr = host_wr && (host_addr == A_HCSR);

    dbm_link #(.RST_CYCLES(RST_CYCLES)) u_link (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr),
        .wr_rdy(host_wdata[B_RDY]), .wr_rst(host_wdata[B_RST]),
        .wr_ig(host_wdata[B_IG]), .state(state), .clr(clr),
        .flush(flush), .armed(armed)
    );

    dbm_ring #(.DEPTH(DEPTH), .DATA_W(32)) u_h2c (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(host_wr && host_addr == A_PUSH && !flush),
        .push_data(host_wdata), .pop(ctl_pop), .pop_data(ctl_rdata),
        .wr_ptr(h_wp), .rd_ptr(h_rp), .ovf(h_ovf)
    );

    dbm_ring #(.DEPTH(DEPTH), .DATA_W(32)) u_c2h (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(ctl_push && !flush), .push_data(ctl_wdata),
        .pop(host_rd && host_addr == A_POP), .pop_data(h_pop_data),
        .wr_ptr(c_wp), .rd_ptr(c_rp), .ovf(c_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_sts <= 1'b0;
            int_en  <= 1'b0;
            bell_q  <= 1'b0;
        end else begin
            bell_q <= csr_wr && host_wdata[B_IG];
            if (csr_wr) int_en <= host_wdata[B_IE];
            if (ctl_ring)                         int_sts <= 1'b1;
            else if (csr_wr && host_wdata[B_IS])  int_sts <= 1'b0;
        end
    end

    always_comb begin
        logic [31:0] hcsr, ccsr;
        hcsr = '0;
        hcsr[31:24] = FIELD_W'(DEPTH);
        hcsr[23:16] = FIELD_W'(h_rp);
        hcsr[15:8]  = FIELD_W'(h_wp);
        hcsr[B_OVF] = h_ovf;
        hcsr[B_RDY] = armed;
        hcsr[B_RST] = flush;
        hcsr[B_IS]  = int_sts;
        hcsr[B_IE]  = int_en;
        ccsr = '0;
        ccsr[31:24] = FIELD_W'(DEPTH);
        ccsr[23:16] = FIELD_W'(c_rp);
        ccsr[15:8]  = FIELD_W'(c_wp);
        ccsr[B_OVF] = c_ovf;
        ccsr[B_RDY] = ctl_ready_in && !flush;
        ccsr[B_RST] = flush;
        unique case (host_addr)
            A_HCSR:  host_rdata = hcsr;
            A_CCSR:  host_rdata = ccsr;
            A_POP:   host_rdata = h_pop_data;
            default: host_rdata = '0;
        endcase
        host_irq     = int_sts && int_en;
        ctl_count    = FIELD_W'(h_wp - h_rp);
        ctl_doorbell = bell_q;
        ctl_flush    = flush;
    end

    p_doorbell_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && host_wdata[B_IG]) |=> ctl_doorbell);
    p_ring_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ring |=> (host_irq == int_en));
    p_flush_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !clr) |=> ($stable(h_wp) && $stable(c_wp)));
endmodule

// File: tb/dbell_mbox_bench.sv
module dbell_mbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int RSTC  = 4;

    logic clk = 0, rst_n = 0;
    logic [1:0] host_addr = 0;
    logic host_wr = 0, host_rd = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic host_irq;
    logic ctl_push = 0, ctl_pop = 0, ctl_ready_in = 1, ctl_ring = 0;
    logic [31:0] ctl_wdata = 0, ctl_rdata;
    logic [7:0] ctl_count;
    logic ctl_doorbell, ctl_flush;

    int checks = 0, errors = 0;
    logic [31:0] exp_h2c[$];
    logic [31:0] exp_c2h[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_mbox #(.DEPTH(DEPTH), .RST_CYCLES(RSTC)) u_dbell_mbox (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .ctl_push(ctl_push), .ctl_wdata(ctl_wdata),
        .ctl_pop(ctl_pop), .ctl_rdata(ctl_rdata), .ctl_count(ctl_count),
        .ctl_ready_in(ctl_ready_in), .ctl_ring(ctl_ring),
        .ctl_doorbell(ctl_doorbell), .ctl_flush(ctl_flush)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(posedge clk); #1;
        host_wr = 0;
    endtask

    function automatic logic [31:0] peek(input logic [1:0] a);
        host_addr = a;
        return 32'h0;
    endfunction

    task automatic hread(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = (a == 2'd3);
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 0;
    endtask

    task automatic drive_h2c(input logic [31:0] d);
        hwrite(2'd1, d);
        exp_h2c.push_back(d);
    endtask

    task automatic drive_c2h(input logic [31:0] d);
        @(negedge clk);
        ctl_push = 1; ctl_wdata = d;
        @(posedge clk); #1;
        ctl_push = 0;
        exp_c2h.push_back(d);
    endtask

    task automatic mon_ctl_pop(input string req);
        logic [31:0] e;
        @(negedge clk);
        e = (exp_h2c.size() > 0) ? exp_h2c.pop_front() : 32'h0;
        ctl_pop = 1;
        #1 chk(req, ctl_rdata, e);
        @(posedge clk); #1;
        ctl_pop = 0;
    endtask

    task automatic mon_host_pop(input string req);
        logic [31:0] e, d;
        e = (exp_c2h.size() > 0) ? exp_c2h.pop_front() : 32'h0;
        hread(2'd3, d);
        chk(req, d, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int fl;
        void'(peek(2'd0));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        hread(2'd0, d); chk("R1 host csr", d, {8'd32, 24'h0});
        chk("R1 irq", {31'h0, host_irq}, 0);
        chk("R1 doorbell", {31'h0, ctl_doorbell}, 0);
        hread(2'd2, d); chk("R1 ctl csr", d, {8'd32, 16'h0, 8'h10});

        // R7/R8 arm with doorbell
        hwrite(2'd0, 32'h14);
        chk("R8 doorbell high", {31'h0, ctl_doorbell}, 1);
        @(posedge clk); #1;
        chk("R8 doorbell one cycle", {31'h0, ctl_doorbell}, 0);
        hread(2'd0, d); chk("R7 armed", {31'h0, d[4]}, 1);

        // R2 host to controller
        for (int i = 0; i < 5; i++) drive_h2c(32'hA000_0000 + i);
        chk("R2 ctl_count", {24'h0, ctl_count}, 5);
        hread(2'd0, d); chk("R2 wr ptr", {24'h0, d[15:8]}, 5);
        for (int i = 0; i < 5; i++) mon_ctl_pop("R2 order");
        hread(2'd0, d); chk("R2 rd ptr", {24'h0, d[23:16]}, 5);

        // R4 controller to host
        for (int i = 0; i < 3; i++) drive_c2h(32'hC0DE_0000 + i);
        hread(2'd2, d); chk("R4 available", {24'h0, d[15:8] - d[23:16]}, 3);
        for (int i = 0; i < 3; i++) mon_host_pop("R4 order");
        hread(2'd2, d); chk("R4 rd ptr", {24'h0, d[23:16]}, 3);

        // R5 empty pops
        mon_host_pop("R5 host empty");
        hread(2'd2, d); chk("R5 rd ptr held", {24'h0, d[23:16]}, 3);
        mon_ctl_pop("R5 ctl empty");
        hread(2'd0, d); chk("R5 ctl rd ptr held", {24'h0, d[23:16]}, 5);

        // R9/R10 interrupt status and enable
        @(negedge clk); ctl_ring = 1; @(posedge clk); #1 ctl_ring = 0;
        hread(2'd0, d); chk("R9 ring sets status", {31'h0, d[1]}, 1);
        chk("R10 irq masked", {31'h0, host_irq}, 0);
        hwrite(2'd0, 32'h11);
        chk("R10 irq on", {31'h0, host_irq}, 1);
        hwrite(2'd0, 32'h11);
        chk("R9 write zero keeps", {31'h0, host_irq}, 1);
        hwrite(2'd0, 32'h13);
        chk("R9 w1c clears", {31'h0, host_irq}, 0);

        // R3 fill and overflow
        for (int i = 0; i < DEPTH - 5; i++) drive_h2c(32'hB000_0000 + i);
        hread(2'd0, d); chk("R3 full ptr", {24'h0, d[15:8]}, DEPTH);
        chk("R3 no ovf yet", {31'h0, d[5]}, 0);
        hwrite(2'd1, 32'hDEAD_BEEF);
        hread(2'd0, d); chk("R3 dropped ptr", {24'h0, d[15:8]}, DEPTH);
        chk("R3 ovf set", {31'h0, d[5]}, 1);
        for (int i = 0; i < DEPTH - 5; i++) mon_ctl_pop("R3 contents");
        mon_ctl_pop("R3 dropped word absent");
        hread(2'd0, d); chk("R3 ovf sticky", {31'h0, d[5]}, 1);

        // R6 reset without ig ignored
        hwrite(2'd0, 32'h19);
        hread(2'd0, d); chk("R6 reset w/o ig ignored", {24'h0, d[15:8]}, DEPTH);

        // R6 reset handshake
        hwrite(2'd0, 32'h0C);
        fl = 0;
        host_addr = 2'd2;
        for (int i = 0; i < RSTC + 3; i++) begin
            if (host_rdata[3]) begin
                fl++;
                chk("R6 ready masked", {31'h0, host_rdata[4]}, 0);
            end
            @(posedge clk); #1;
        end
        chk("R6 flush length", fl, RSTC);
        hread(2'd0, d);
        chk("R6 ptrs cleared", {16'h0, d[23:8]}, 0);
        chk("R6 ovf cleared", {31'h0, d[5]}, 0);
        chk("R7 idle after flush", {31'h0, d[4]}, 0);

        // R11 pushes during flush dropped
        hwrite(2'd0, 32'h0C);
        hwrite(2'd1, 32'h1234_5678);
        @(negedge clk); ctl_push = 1; ctl_wdata = 32'h55; @(posedge clk); #1 ctl_push = 0;
        repeat (RSTC + 1) @(posedge clk);
        #1;
        hread(2'd0, d); chk("R11 host push dropped", {24'h0, d[15:8]}, 0);
        chk("R11 no ovf", {31'h0, d[5]}, 0);
        hread(2'd2, d); chk("R11 ctl push dropped", {24'h0, d[15:8]}, 0);

        // R7 arm and disarm
        hwrite(2'd0, 32'h10);
        hread(2'd0, d); chk("R7 rearmed", {31'h0, d[4]}, 1);
        hwrite(2'd0, 32'h00);
        hread(2'd0, d); chk("R7 disarm", {31'h0, d[4]}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule